// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block finds and holds frame alignment on a 2048 kbit/s E1 bit stream. A frame is 256 bits, organised as 32 timeslots of 8 bits. The stream arrives one bit per clock in which `bit_en_i` is high. While the block is out of frame, a 7-bit comparator checks every incoming bit against the alignment word. A match sets the position counters to that bit. Two more frames then confirm or reject the candidate. If a candidate fails, the search continues from the next bit, so the bit position being tested moves along the stream one bit at a time.

Once aligned, the block checks only the alignment word slot and the bit-2 slot of the alternate frame. It drops alignment after repeated errors there, or when the CRC monitor pulses `resync_i`. The outputs give a frame-start strobe, the timeslot and bit position of the current bit, which of the two alternating frames is running, and the in-frame status. A remote alarm request goes to the local transmitter, which sets the A bit while the block is out of frame.

Top module: `e1_frame_aligner`

## Requirements
- R1: The alignment word is 0011011 and occupies bits 2 to 8 of timeslot 0 in alternate frames. Bit 1 of a timeslot is the first of its 8 bits on the line. While out of frame, the word is searched for on every accepted bit.
- R2: `in_frame_o` rises only after three steps: a correct alignment word, then a bit 2 of timeslot 0 equal to one in the next frame, then a correct alignment word in the frame after that. It rises in the cycle after bit 8 of timeslot 0 of that third frame is accepted.
- R3: During confirmation, two events abandon the candidate and resume the bit-by-bit search: a zero in the bit-2 slot, or an errored word in the second alignment-word slot.
- R4: While in frame, one or two consecutive errored alignment words keep alignment. The third consecutive errored word drops `in_frame_o`.
- R5: With `nfas_loss_en_i` high, the third consecutive alternate frame with bit 2 of timeslot 0 at zero drops alignment, and one or two such frames do not. With `nfas_loss_en_i` low, a zero in that bit has no effect.
- R6: A high `resync_i` forces the out-of-frame search in the next cycle, whatever the current state.
- R7: `ts_o` (0 to 31) and `bit_o` (0 to 7, where 0 means bit 1) give the position of the bit currently on `data_i`. `frame_start_o` is high in the `bit_en_i` cycle that carries bit 1 of timeslot 0, and only while in frame. `fas_frame_o` is high for the whole frame that carries the alignment word and toggles at every frame start.
- R8: `rai_req_o` is high whenever the block is not in frame, including after reset. After reset `in_frame_o` and `frame_start_o` are low.
- R9: A copy of the alignment word placed in another timeslot, with a zero where bit 2 of the alternate frame is expected, never leads to alignment.
- R10: Cycles with `bit_en_i` low have no effect on the counters, the comparator or the state, whatever is on `data_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_en_i | input | 1 | High in cycles that carry a line bit |
| data_i | input | 1 | Serial line bit |
| resync_i | input | 1 | Force a new frame search (from the CRC monitor) |
| nfas_loss_en_i | input | 1 | Enable loss of alignment on bit-2 errors |
| frame_start_o | output | 1 | Bit 1 of timeslot 0 is on `data_i` (in frame only) |
| ts_o | output | 5 | Current timeslot, 0 to 31 |
| bit_o | output | 3 | Current bit in timeslot, 0 means bit 1 |
| fas_frame_o | output | 1 | Current frame carries the alignment word |
| in_frame_o | output | 1 | Frame alignment held |
| rai_req_o | output | 1 | Request the A bit in transmitted frames |

## Verification
The first lock runs on clean frames in which the idle cycles carry the inverse of each line bit. This tells bit gating apart from sampling on every clock. Frames with one, two and three errored alignment words in a row, and with the bit-2 slot cleared with the loss option on and off, separate the tolerance limits from the loss thresholds. Candidates broken at each confirmation step, together with a stream whose only alignment-word copy sits in timeslot 15, distinguish a full three-step confirmation from acceptance on the word alone. Resync pulses confirm that the search restarts at once and reacquires within two frame pairs.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_NFAS = 2'd1,
    ST_CONF = 2'd2,
    ST_SYNC = 2'd3
  } align_st_e;

  localparam int FAS_LEN = 7;
  localparam logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011;
endpackage

// File: rtl/e1fa_pos_cnt.sv
module e1fa_pos_cnt #(
  parameter  int TS_N   = 32,
  parameter  int BITS_N = 8,
  localparam int TS_W   = $clog2(TS_N),
  localparam int BIT_W  = $clog2(BITS_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  output logic [TS_W-1:0]  ts_o,
  output logic [BIT_W-1:0] bit_o,
  output logic             fas_frame_o
);
  logic [TS_W-1:0]  ts_q;
  logic [BIT_W-1:0] bit_q;
  logic             fas_q;
  logic             last_bit, last_ts;

  assign last_bit = (bit_q == BIT_W'(BITS_N-1));
  assign last_ts  = (ts_q == TS_W'(TS_N-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_q  <= '0;
      bit_q <= '0;
      fas_q <= 1'b0;
    end else if (load_i) begin
      // hit was on the last bit of timeslot 0 of a FAS frame
      ts_q  <= TS_W'(1);
      bit_q <= '0;
      fas_q <= 1'b1;
    end else if (adv_i) begin
      if (last_bit) begin
        bit_q <= '0;
        if (last_ts) begin
          ts_q  <= '0;
          fas_q <= ~fas_q;
        end else begin
          ts_q <= ts_q + 1'b1;
        end
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign ts_o        = ts_q;
  assign bit_o       = bit_q;
  assign fas_frame_o = fas_q;

  AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && last_ts && last_bit |=> ts_q == '0 && bit_q == '0 && fas_q != $past(fas_q)); // R7
  AST_LOAD_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ts_q == TS_W'(1) && bit_q == '0 && fas_q); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && !load_i |=> $stable(ts_q) && $stable(bit_q) && $stable(fas_q)); // R10
endmodule

// File: rtl/e1fa_fas_cmp.sv
module e1fa_fas_cmp
  import e1fa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic data_i,
  output logic hit_o
);
  logic [FAS_LEN-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else if (adv_i) sr_q <= {sr_q[FAS_LEN-3:0], data_i};
  end

  // current bit completes the window
  assign hit_o = adv_i && ({sr_q, data_i} == FAS_WORD);
endmodule

// File: rtl/e1fa_align_fsm.sv
module e1fa_align_fsm
  import e1fa_pkg::*;
#(
  parameter  int LOSS_N = 3,
  localparam int CNT_W  = $clog2(LOSS_N+1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic data_i,
  input  logic hit_i,
  input  logic fas_slot_i,
  input  logic nfas_slot_i,
  input  logic resync_i,
  input  logic nfas_loss_en_i,
  output logic load_o,
  output logic in_frame_o
);
  align_st_e        st_q, st_d;
  logic [CNT_W-1:0] miss_q, miss_d, b2_q, b2_d;

  always_comb begin
    st_d   = st_q;
    miss_d = miss_q;
    b2_d   = b2_q;
    load_o = 1'b0;
    case (st_q)
      ST_HUNT: if (hit_i) begin
        load_o = 1'b1;
        st_d   = ST_NFAS;
      end
      ST_NFAS: if (adv_i && nfas_slot_i) st_d = data_i ? ST_CONF : ST_HUNT;
      ST_CONF: if (adv_i && fas_slot_i)  st_d = hit_i ? ST_SYNC : ST_HUNT;
      ST_SYNC: begin
        if (adv_i && fas_slot_i) begin
          if (hit_i) miss_d = '0;
          else if (miss_q == CNT_W'(LOSS_N-1)) st_d = ST_HUNT;
          else miss_d = miss_q + 1'b1;
        end
        if (adv_i && nfas_slot_i) begin
          if (data_i || !nfas_loss_en_i) b2_d = '0;
          else if (b2_q == CNT_W'(LOSS_N-1)) st_d = ST_HUNT;
          else b2_d = b2_q + 1'b1;
        end
      end
      default: st_d = ST_HUNT;
    endcase
    if (resync_i) begin
      st_d   = ST_HUNT;
      load_o = 1'b0;
    end
    if (st_d != ST_SYNC) begin
      miss_d = '0;
      b2_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      miss_q <= '0;
      b2_q   <= '0;
    end else begin
      st_q   <= st_d;
      miss_q <= miss_d;
      b2_q   <= b2_d;
    end
  end

  assign in_frame_o = (st_q == ST_SYNC);

  AST_LOCK_AT_FAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_frame_o) |-> $past(fas_slot_i && hit_i && !resync_i)); // R2
  AST_DROP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_frame_o) |-> $past(resync_i || (adv_i && (fas_slot_i || nfas_slot_i)))); // R4
  AST_RESYNC_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> !in_frame_o); // R6
endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner #(
  parameter int TS_N   = 32,
  parameter int BITS_N = 8,
  parameter int LOSS_N = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      bit_en_i,
  input  logic                      data_i,
  input  logic                      resync_i,
  input  logic                      nfas_loss_en_i,
  output logic                      frame_start_o,
  output logic [$clog2(TS_N)-1:0]   ts_o,
  output logic [$clog2(BITS_N)-1:0] bit_o,
  output logic                      fas_frame_o,
  output logic                      in_frame_o,
  output logic                      rai_req_o
);
  localparam int TS_W  = $clog2(TS_N);
  localparam int BIT_W = $clog2(BITS_N);

  logic             hit, load, in_frame, fas_frame;
  logic [TS_W-1:0]  ts;
  logic [BIT_W-1:0] bit_pos;
  logic             fas_slot, nfas_slot;

  e1fa_fas_cmp u_cmp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (bit_en_i),
    .data_i (data_i),
    .hit_o  (hit)
  );

  e1fa_pos_cnt #(.TS_N(TS_N), .BITS_N(BITS_N)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (bit_en_i),
    .load_i      (load),
    .ts_o        (ts),
    .bit_o       (bit_pos),
    .fas_frame_o (fas_frame)
  );

  // slot decodes: last bit of ts0 in FAS frame, bit 2 of ts0 otherwise
  assign fas_slot  = (ts == '0) && (bit_pos == BIT_W'(BITS_N-1)) && fas_frame;
  assign nfas_slot = (ts == '0) && (bit_pos == BIT_W'(1)) && !fas_frame;

  e1fa_align_fsm #(.LOSS_N(LOSS_N)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .adv_i          (bit_en_i),
    .data_i         (data_i),
    .hit_i          (hit),
    .fas_slot_i     (fas_slot),
    .nfas_slot_i    (nfas_slot),
    .resync_i       (resync_i),
    .nfas_loss_en_i (nfas_loss_en_i),
    .load_o         (load),
    .in_frame_o     (in_frame)
  );

  assign frame_start_o = bit_en_i && in_frame && (ts == '0) && (bit_pos == '0);
  assign ts_o          = ts;
  assign bit_o         = bit_pos;
  assign fas_frame_o   = fas_frame;
  assign in_frame_o    = in_frame;
  assign rai_req_o     = ~in_frame;

  AST_START_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> bit_o == BIT_W'(1) && ts_o == '0); // R7
endmodule

// File: tb/e1_frame_aligner_bench.sv
module e1_frame_aligner_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_en = 1'b0, data = 1'b0, resync = 1'b0, loss_en = 1'b0;
  logic fs, fas_f, in_f, rai;
  logic [4:0] ts;
  logic [2:0] bi;

  int n_run = 0, n_fail = 0;
  logic phase = 1'b1;
  logic fs0, ff0;
  logic [4:0] ts_s;
  logic [2:0] bi_s;

  e1_frame_aligner u_e1_frame_aligner (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .data_i(data),
    .resync_i(resync), .nfas_loss_en_i(loss_en), .frame_start_o(fs),
    .ts_o(ts), .bit_o(bi), .fas_frame_o(fas_f), .in_frame_o(in_f),
    .rai_req_o(rai)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // good: word correct in FAS frame; b2: bit 2 in alternate frame; cp: word copy in ts15
  task automatic send_frame(input logic good, input logic b2, input logic cp);
    for (int p = 0; p < 256; p++) begin
      int t = p / 8;
      int b = p % 8;
      logic [6:0] w;
      logic v;
      w = good ? 7'b0011011 : 7'b0011010;
      v = 1'b1;
      if (t == 0 && b != 0) begin
        if (phase) v = w[7-b];
        else if (b == 1) v = b2;
      end else if (t == 15 && cp && b != 0) begin
        v = 7'b0011011 >> (7 - b);
      end
      @(negedge clk);
      data = v;
      bit_en = 1'b1;
      #2;
      if (p == 0) begin fs0 = fs; ff0 = fas_f; end
      if (p == 100) begin ts_s = ts; bi_s = bi; end
      @(negedge clk);
      bit_en = 1'b0;
      data = ~v;
    end
    phase = ~phase;
  endtask

  task automatic pulse_resync();
    @(negedge clk); resync = 1'b1;
    @(negedge clk); resync = 1'b0;
  endtask

  task automatic t_reset();
    chk("R8 in_frame after reset", in_f, 0);
    chk("R8 rai after reset", rai, 1);
    chk("R8 frame_start after reset", fs, 0);
  endtask

  task automatic t_lock();
    send_frame(1, 1, 0);
    chk("R2 no lock after first word", in_f, 0);
    send_frame(1, 1, 0);
    chk("R2 no lock after bit-2 frame", in_f, 0);
    send_frame(1, 1, 0);
    chk("R2 R10 R1 lock after third frame", in_f, 1);
    chk("R8 rai low in frame", rai, 0);
    send_frame(1, 1, 0);
    chk("R7 frame_start at ts0 bit1", fs0, 1);
    chk("R7 fas_frame low in alternate frame", ff0, 0);
    chk("R7 ts at bit 100", ts_s, 12);
    chk("R7 bit at bit 100", bi_s, 4);
    send_frame(1, 1, 0);
    chk("R7 fas_frame high in word frame", ff0, 1);
  endtask

  task automatic t_fas_err();
    send_frame(1, 1, 0);
    send_frame(0, 1, 0);
    send_frame(1, 1, 0);
    send_frame(0, 1, 0);
    chk("R4 two errored words keep frame", in_f, 1);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(0, 1, 0);
    send_frame(1, 1, 0);
    send_frame(0, 1, 0);
    send_frame(1, 1, 0);
    chk("R4 still in frame before third", in_f, 1);
    send_frame(0, 1, 0);
    chk("R4 third errored word drops", in_f, 0);
    chk("R8 rai after loss", rai, 1);
    send_frame(1, 1, 0);
    chk("R7 no frame_start out of frame", fs0, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    chk("R2 relock after loss", in_f, 1);
  endtask

  task automatic t_restart();
    pulse_resync();
    chk("R6 resync drops frame", in_f, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(1, 0, 0);
    send_frame(1, 1, 0);
    chk("R3 bit-2 zero restarts search", in_f, 0);
    send_frame(1, 1, 0);
    send_frame(0, 1, 0);
    chk("R3 errored second word restarts", in_f, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    chk("R3 lock after restart", in_f, 1);
  endtask

  task automatic t_b2_loss();
    loss_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      send_frame(1, 0, 0);
      send_frame(1, 1, 0);
    end
    chk("R5 bit-2 zero ignored when disabled", in_f, 1);
    loss_en = 1'b1;
    send_frame(1, 0, 0);
    send_frame(1, 1, 0);
    send_frame(1, 0, 0);
    send_frame(1, 1, 0);
    chk("R5 two bit-2 errors keep frame", in_f, 1);
    send_frame(1, 0, 0);
    chk("R5 third bit-2 error drops", in_f, 0);
    loss_en = 1'b0;
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    send_frame(1, 1, 0);
    chk("R5 relock after bit-2 loss", in_f, 1);
  endtask

  task automatic t_copy();
    pulse_resync();
    for (int k = 0; k < 6; k++) send_frame(0, 1, 1);
    chk("R9 word copy in ts15 rejected", in_f, 0);
    for (int k = 0; k < 8; k++) send_frame(1, 1, 0);
    chk("R9 lock once copy removed", in_f, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_lock();
    t_fas_err();
    t_restart();
    t_b2_loss();
    t_copy();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule